// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers asynchronous serial characters from a single receive line. A clock running at 1, 16 or 64 times the bit rate samples the line. A configuration input sets the data length (5 to 8 bits), the parity mode (none, odd or even) and whether one or two stop bits are checked. Each finished character is placed right-justified on a parallel output, and a ready flag is raised with it.

A processor-side read strobe lowers the ready flag. Parity, overrun and framing errors are kept as sticky flags until an explicit clear input is pulsed. A start edge that has gone away by the middle of the start bit is thrown away as noise. A character whose every sampled position is low, stop bits included, raises a break indication. After any frame whose stop bit was low, the receiver waits for the line to return high before it looks for another start bit.

Top module: `serial_rx_core`

## Requirements
- R1: `cfg_len_i` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive LSB first. The character appears right-justified on `data_o`, and the unused upper bits read as zero.
- R2: `cfg_baud_i` selects the sampling factor: 0 is 1x, 1 is 16x, and 2 or 3 is 64x. At 16x and 64x every bit is sampled at the middle count of its period. At 1x every bit is sampled once, in the clock where it is present.
- R3: `cfg_par_i[0]` enables a parity bit after the data bits, and `cfg_par_i[1]` selects even (1) or odd (0). A mismatch sets `par_err_o`.
- R4: At 16x and 64x, a low level that is high again at the middle of the start bit is discarded. No character is produced, and the next real frame is received correctly.
- R5: A completed frame sets `rdy_o` and updates `data_o`. A pulse on `rd_i` clears `rdy_o`.
- R6: If a frame completes while `rdy_o` is still set, `ovr_err_o` is set and `data_o` takes the newer character.
- R7: A low first stop bit sets `frm_err_o`. When `cfg_stop2_i` is 1, a low second stop bit also sets it.
- R8: A frame whose data, parity and stop positions are all low sets `brk_o`, which clears once the line is high again. After a low stop bit, no new frame is started until the line has been high.
- R9: `par_err_o`, `ovr_err_o` and `frm_err_o` hold until `err_clr_i` is pulsed, which clears all three.
- R10: After reset, `rdy_o`, `data_o`, all error flags and `brk_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial receive line, idle high |
| cfg_len_i | input | 2 | Data length select |
| cfg_par_i | input | 2 | Bit 0 enables parity, bit 1 selects even |
| cfg_stop2_i | input | 1 | Check a second stop bit |
| cfg_baud_i | input | 2 | Sampling factor select |
| rd_i | input | 1 | Read strobe, clears ready |
| err_clr_i | input | 1 | Clears the sticky error flags |
| data_o | output | 8 | Received character |
| rdy_o | output | 1 | Character ready |
| par_err_o | output | 1 | Sticky parity error |
| ovr_err_o | output | 1 | Sticky overrun error |
| frm_err_o | output | 1 | Sticky framing error |
| brk_o | output | 1 | Break detected |

## Verification
The hardest situation to reach from the ports is a break held low well past one frame. The receiver must flag the break once, then refuse to assemble further all-zero characters, and then drop the flag only when the line rises. The bench holds the line low for many frame times and reads the character out while the line is still low, so that any second frame would show up as a fresh ready flag. Only after that does it release the line and look for `brk_o` to fall. The false start case is reached in the same way: the bench drives a low pulse shorter than half a bit at 16x, waits longer than a frame, checks that ready stayed low, and then sends a real frame.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W  = 8;
  localparam int MAX_DIV = 64;
  localparam int CNT_W   = $clog2(MAX_DIV);
  localparam int IDX_W   = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2, ST_WAIT_HI
  } rx_state_e;

  // last count of a bit period for a factor code
  function automatic logic [CNT_W-1:0] last_cnt(input logic [1:0] code);
    case (code)
      2'd0:    return '0;
      2'd1:    return CNT_W'(15);
      default: return CNT_W'(MAX_DIV - 1);
    endcase
  endfunction

  // mid-bit count within the start bit
  function automatic logic [CNT_W-1:0] mid_cnt(input logic [1:0] code);
    return CNT_W'((int'(last_cnt(code)) + 1) / 2 - 1);
  endfunction
endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import srx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic [1:0]        cfg_len_i,
  input  logic [1:0]        cfg_par_i,
  input  logic              cfg_stop2_i,
  input  logic [1:0]        cfg_baud_i,
  output logic              done_o,
  output logic [DATA_W-1:0] char_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o
);
  rx_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q, zero_q, ferr_q;

  logic [CNT_W-1:0] tgt;
  logic             tick, x1;
  logic [IDX_W-1:0] last_idx;
  logic             fe_n, zero_n, pe_n;

  assign x1       = (cfg_baud_i == 2'd0);
  assign tgt      = (st_q == ST_START) ? mid_cnt(cfg_baud_i) : last_cnt(cfg_baud_i);
  assign tick     = (cnt_q == tgt);
  assign last_idx = IDX_W'(cfg_len_i) + IDX_W'(4);
  assign fe_n     = ferr_q | ~line_i;
  assign zero_n   = zero_q & ~line_i;
  // accumulated xor over data+parity: odd wants 1, even wants 0
  assign pe_n     = cfg_par_i[0] & (par_q ^ ~cfg_par_i[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      zero_q <= 1'b1;
      ferr_q <= 1'b0;
      done_o <= 1'b0;
      char_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
      brk_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (!line_i) begin
          cnt_q  <= '0;
          idx_q  <= '0;
          sh_q   <= '0;
          par_q  <= 1'b0;
          zero_q <= 1'b1;
          ferr_q <= 1'b0;
          st_q   <= x1 ? ST_DATA : ST_START;
        end
        ST_START: begin
          cnt_q <= tick ? '0 : cnt_q + 1'b1;
          if (tick) st_q <= line_i ? ST_IDLE : ST_DATA;  // false start rejected
        end
        ST_DATA: begin
          cnt_q <= tick ? '0 : cnt_q + 1'b1;
          if (tick) begin
            sh_q[idx_q] <= line_i;
            par_q       <= par_q ^ line_i;
            zero_q      <= zero_n;
            if (idx_q == last_idx) st_q <= cfg_par_i[0] ? ST_PAR : ST_STOP1;
            else                   idx_q <= idx_q + 1'b1;
          end
        end
        ST_PAR: begin
          cnt_q <= tick ? '0 : cnt_q + 1'b1;
          if (tick) begin
            par_q  <= par_q ^ line_i;
            zero_q <= zero_n;
            st_q   <= ST_STOP1;
          end
        end
        ST_STOP1, ST_STOP2: begin
          cnt_q <= tick ? '0 : cnt_q + 1'b1;
          if (tick) begin
            ferr_q <= fe_n;
            zero_q <= zero_n;
            if (st_q == ST_STOP1 && cfg_stop2_i) begin
              st_q <= ST_STOP2;
            end else begin
              done_o <= 1'b1;
              char_o <= sh_q;
              perr_o <= pe_n;
              ferr_o <= fe_n;
              brk_o  <= zero_n;
              st_q   <= fe_n ? ST_WAIT_HI : ST_IDLE;
            end
          end
        end
        ST_WAIT_HI: if (line_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              brk_i,
  input  logic              rd_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              par_err_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              brk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      rdy_o     <= 1'b0;
      par_err_o <= 1'b0;
      ovr_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      brk_o     <= 1'b0;
    end else begin
      if (err_clr_i) begin
        par_err_o <= 1'b0;
        ovr_err_o <= 1'b0;
        frm_err_o <= 1'b0;
      end
      if (rd_i) rdy_o <= 1'b0;
      if (line_i) brk_o <= 1'b0;
      // a new frame wins over read and clear in the same cycle
      if (done_i) begin
        data_o <= char_i;
        rdy_o  <= 1'b1;
        if (rdy_o && !rd_i) ovr_err_o <= 1'b1;
        if (perr_i) par_err_o <= 1'b1;
        if (ferr_i) frm_err_o <= 1'b1;
        if (brk_i)  brk_o     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic [1:0]        cfg_len_i,
  input  logic [1:0]        cfg_par_i,
  input  logic              cfg_stop2_i,
  input  logic [1:0]        cfg_baud_i,
  input  logic              rd_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              par_err_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              brk_o
);
  logic              line_s;
  logic              frm_done, frm_perr, frm_ferr, frm_brk;
  logic [DATA_W-1:0] frm_char;

  srx_line_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  srx_frame_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_s),
    .cfg_len_i  (cfg_len_i),
    .cfg_par_i  (cfg_par_i),
    .cfg_stop2_i(cfg_stop2_i),
    .cfg_baud_i (cfg_baud_i),
    .done_o     (frm_done),
    .char_o     (frm_char),
    .perr_o     (frm_perr),
    .ferr_o     (frm_ferr),
    .brk_o      (frm_brk)
  );

  srx_status u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_s),
    .done_i   (frm_done),
    .char_i   (frm_char),
    .perr_i   (frm_perr),
    .ferr_i   (frm_ferr),
    .brk_i    (frm_brk),
    .rd_i     (rd_i),
    .err_clr_i(err_clr_i),
    .data_o   (data_o),
    .rdy_o    (rdy_o),
    .par_err_o(par_err_o),
    .ovr_err_o(ovr_err_o),
    .frm_err_o(frm_err_o),
    .brk_o    (brk_o)
  );
endmodule

// File: rtl/srx_checks.sv
module srx_checks (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_s,
  input logic       frm_done,
  input logic [1:0] cfg_len_i,
  input logic       rd_i,
  input logic       err_clr_i,
  input logic [7:0] data_o,
  input logic       rdy_o,
  input logic       par_err_o,
  input logic       ovr_err_o,
  input logic       frm_err_o,
  input logic       brk_o
);
  a_r5_rdy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_done |=> rdy_o);

  a_r5_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && rd_i && !frm_done) |=> !rdy_o);

  a_r6_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_done && rdy_o && !rd_i) |=> ovr_err_o);

  a_r9_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_err_o && !err_clr_i) |=> ovr_err_o);

  a_r9_par_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o && !err_clr_i) |=> par_err_o);

  a_r9_frm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_err_o && !err_clr_i) |=> frm_err_o);

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !frm_done) |=> (!par_err_o && !ovr_err_o && !frm_err_o));

  a_r8_brk_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_s && !frm_done) |=> !brk_o);

  a_r1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_done && cfg_len_i == 2'd0) |=> (data_o[7:5] == 3'b000));
endmodule

bind serial_rx_core srx_checks u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .line_s   (line_s),
  .frm_done (frm_done),
  .cfg_len_i(cfg_len_i),
  .rd_i     (rd_i),
  .err_clr_i(err_clr_i),
  .data_o   (data_o),
  .rdy_o    (rdy_o),
  .par_err_o(par_err_o),
  .ovr_err_o(ovr_err_o),
  .frm_err_o(frm_err_o),
  .brk_o    (brk_o)
);

// File: tb/serial_rx_core_test.sv
`timescale 1ns/1ps
module serial_rx_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0, cfg_baud = 2'd1;
  logic       cfg_stop2 = 1'b0, rd = 1'b0, err_clr = 1'b0;
  logic [7:0] data;
  logic       rdy, perr, oerr, ferr, brk;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  serial_rx_core uut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd),
    .cfg_len_i(cfg_len), .cfg_par_i(cfg_par), .cfg_stop2_i(cfg_stop2),
    .cfg_baud_i(cfg_baud), .rd_i(rd), .err_clr_i(err_clr),
    .data_o(data), .rdy_o(rdy), .par_err_o(perr), .ovr_err_o(oerr),
    .frm_err_o(ferr), .brk_o(brk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 16 : 64;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] len, input logic [1:0] par,
                     input logic stop2, input logic [1:0] baud);
    cfg_len = len; cfg_par = par; cfg_stop2 = stop2; cfg_baud = baud;
    idle(2);
  endtask

  task automatic pulse_rd_clr();
    rd = 1'b1; err_clr = 1'b1;
    @(negedge clk);
    rd = 1'b0; err_clr = 1'b0;
    @(negedge clk);
  endtask

  // drives one frame from the current cfg; pflip corrupts parity, s1/s2 are stop levels
  task automatic send(input logic [7:0] d, input logic pflip, input logic s1, input logic s2);
    int  div = div_of(cfg_baud);
    int  nb  = int'(cfg_len) + 5;
    logic [7:0] m = d & (8'hFF >> (8 - nb));
    logic p = cfg_par[1] ? ^m : ~^m;
    rxd = 1'b0; idle(div);
    for (int i = 0; i < nb; i++) begin rxd = m[i]; idle(div); end
    if (cfg_par[0]) begin rxd = p ^ pflip; idle(div); end
    rxd = s1; idle(div);
    if (cfg_stop2) begin rxd = s2; idle(div); end
    rxd = 1'b1; idle(2 * div + 8);
  endtask

  task automatic t_reset();
    chk("R10 rdy", rdy, 0);
    chk("R10 data", data, 0);
    chk("R10 errs", {perr, oerr, ferr, brk}, 0);
  endtask

  task automatic t_basic16();
    cfg(2'd3, 2'd0, 1'b0, 2'd1);
    send(8'hA5, 0, 1, 1);
    chk("R5 rdy set", rdy, 1);
    chk("R2 16x data", data, 8'hA5);
    chk("R3/R7 no err", {perr, ferr, oerr}, 0);
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
    chk("R5 rd clears", rdy, 0);
  endtask

  task automatic t_x1_len5();
    cfg(2'd0, 2'd0, 1'b0, 2'd0);
    send(8'hF3, 0, 1, 1);
    chk("R1 len5 right-justified", data, 8'h13);
    chk("R2 1x ready", rdy, 1);
    pulse_rd_clr();
  endtask

  task automatic t_x64_even();
    cfg(2'd2, 2'd3, 1'b0, 2'd2);
    send(8'h5A, 0, 1, 1);
    chk("R2 64x 7bit data", data, 8'h5A);
    chk("R3 even parity ok", perr, 0);
    pulse_rd_clr();
  endtask

  task automatic t_parity_sticky();
    cfg(2'd1, 2'd1, 1'b0, 2'd1);
    send(8'h2C, 1, 1, 1);
    chk("R3 odd parity error", perr, 1);
    chk("R1 len6 data", data, 8'h2C);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    send(8'h11, 0, 1, 1);
    chk("R9 parity sticky", perr, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    chk("R9 clear", {perr, oerr, ferr}, 0);
    pulse_rd_clr();
  endtask

  task automatic t_overrun();
    cfg(2'd3, 2'd0, 1'b0, 2'd1);
    send(8'h01, 0, 1, 1);
    chk("R6 no overrun first", oerr, 0);
    send(8'h7E, 0, 1, 1);
    chk("R6 overrun set", oerr, 1);
    chk("R6 newer data", data, 8'h7E);
    pulse_rd_clr();
  endtask

  task automatic t_framing();
    cfg(2'd3, 2'd0, 1'b0, 2'd1);
    send(8'hC3, 0, 0, 1);
    chk("R7 stop low", ferr, 1);
    chk("R7 data kept", data, 8'hC3);
    chk("R8 no break on data", brk, 0);
    pulse_rd_clr();
    cfg(2'd3, 2'd0, 1'b1, 2'd1);
    send(8'h3C, 0, 1, 1);
    chk("R7 two stops ok", ferr, 0);
    send(8'h3C, 0, 1, 0);
    chk("R7 second stop low", ferr, 1);
    pulse_rd_clr();
  endtask

  task automatic t_false_start();
    cfg(2'd3, 2'd0, 1'b0, 2'd1);
    rxd = 1'b0; idle(4); rxd = 1'b1;
    idle(16 * 12);
    chk("R4 glitch ignored", rdy, 0);
    send(8'h96, 0, 1, 1);
    chk("R4 next frame data", data, 8'h96);
    chk("R4 next frame ready", rdy, 1);
    pulse_rd_clr();
  endtask

  task automatic t_break();
    cfg(2'd3, 2'd1, 1'b0, 2'd1);
    rxd = 1'b0; idle(16 * 14);
    chk("R8 break set", brk, 1);
    chk("R8 break framing", ferr, 1);
    chk("R8 break data", data, 0);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    idle(16 * 30);
    chk("R8 no refire while low", rdy, 0);
    chk("R8 break held", brk, 1);
    rxd = 1'b1; idle(6);
    chk("R8 break released", brk, 0);
    idle(16 * 2);
    send(8'h5F, 0, 1, 1);
    chk("R8 receive after break", data, 8'h5F);
    pulse_rd_clr();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_basic16();
    t_x1_len5();
    t_x64_even();
    t_parity_sticky();
    t_overrun();
    t_framing();
    t_false_start();
    t_break();
    done = 1'b1;
  end

  initial begin : watchdog
    int n = 0;
    while (!done && n < 150000) begin @(posedge clk); n++; end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule